// File: doc/BRIEF.md
# Channel-Partitioned Audio Sample FIFO

This block sits between a register-mapped processor port and an audio serializer on the transmit path. Software writes audio samples one word at a time into a data register. The serializer pulls them out in arrival order. The storage is a single pool of sample words. Its usable depth, counted in frames, halves each time the channel count crosses a power of two, so a mono stream gets the deepest buffer and an eight-channel stream the shallowest.

Software sees three registers, selected by a 2-bit word address:
- address 0: control
- address 1: status
- address 2: sample data (write only)

The status register reports how many whole frames are waiting. It also holds two sticky error flags: one for a write into a full FIFO and one for a pull from an empty FIFO. A request output tells software to refill once the FIFO has drained to half its frame depth. Software can enable or disable this request. A control write can empty the FIFO in one cycle.

Top module: `audio_chan_fifo`

## Requirements
- R1: With N channels (control bits [10:8] hold N-1), the frame depth is 256 for N=1, 128 for N=2, 64 for N=3..4 and 32 for N=5..8. At most depth*N samples are held at once, and a sample write beyond that is dropped.
- R2: Status bits [16:8] give the residue in frames. The residue is the number of complete frames written minus the number of complete frames pulled, both counted since the last clear.
- R3: A sample write (address 2) while the FIFO is full sets status bit 4. The bit stays set until software clears it.
- R4: A serializer pull while the FIFO is empty returns 0 on serData and sets status bit 0. The bit stays set until software clears it.
- R5: A write to the status register (address 1) clears each flag whose bit (4 or 0) is written as zero. A flag whose bit is written as one is left unchanged. Writing zero clears both flags.
- R6: A control write with bit 0 set empties the FIFO by the next cycle, setting the residue to 0. Control bit 0 always reads back as 0, and the clear leaves both error flags unchanged.
- R7: halfReq is high exactly when control bit 20 is set and the residue is at or below half the current frame depth.
- R8: Only bits [23:0] of any register write take effect. A stored sample is returned as the low 24 bits of the written word. Control reads back bit 20 and bits [10:8], with all other bits 0. A read of address 2 returns 0.
- R9: Samples leave in the order they were written. serData is registered: it shows the pulled sample in the cycle after serPop is sampled, and holds its value when serPop is low.
- R10: After reset the FIFO is empty, both flags are clear, the channel count is 1, halfReq is low and serData is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word address: 0 control, 1 status, 2 sample data |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Combinational read data for regAddr |
| serPop | input | 1 | Serializer pulls one sample |
| serData | output | 24 | Registered sample toward the serializer |
| halfReq | output | 1 | Refill request at or below half depth |

## Verification
A corrupted pointer or fill count shows up on serData in the cycle after the next pull, as a sample out of order or a sample that was never written. It also shows up in the residue field, which is visible on the port in the same cycle. A wrong frame depth or a wrong sub-frame counter first shows in the residue or in halfReq when a frame boundary or the half-depth threshold is crossed. A flag that is set or cleared at the wrong time is visible in the status word one cycle after the triggering write or pull. For these reasons the reference model compares the status word, halfReq and serData on every clock.

// File: rtl/achfifo_pkg.sv
package achfifo_pkg;
  localparam int SAMPLE_W = 24;
  localparam int CHAN_W   = 3;
  localparam int RES_W    = 9;

  typedef struct packed {
    logic                push;
    logic                pop;
    logic                popMiss;
    logic                clear;
    logic [SAMPLE_W-1:0] pushData;
    logic [CHAN_W-1:0]   chanM1;
  } strobe_t;

  typedef struct packed {
    logic             full;
    logic             empty;
    logic [RES_W-1:0] frames;
  } fill_t;

  // Shift of the total pool that gives the frame depth per channel count.
  function automatic int unsigned frameShift(input logic [CHAN_W-1:0] m1);
    if (m1 == 3'd0)      return 0;
    else if (m1 == 3'd1) return 1;
    else if (m1 <= 3'd3) return 2;
    else                 return 3;
  endfunction
endpackage

// File: rtl/achfifo_data.sv
module achfifo_data
  import achfifo_pkg::*;
#(
  parameter int TOTAL_WORDS = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  output fill_t               fill,
  output logic [SAMPLE_W-1:0] serData
);
  localparam int AW = $clog2(TOTAL_WORDS);
  localparam int CW = AW + 1;

  logic [SAMPLE_W-1:0] mem [TOTAL_WORDS];
  logic [AW-1:0]       wrPtr, rdPtr;
  logic [CW-1:0]       count;
  logic [CW-1:0]       cap;
  logic [CHAN_W-1:0]   wrSub, rdSub;
  logic [RES_W-1:0]    frames;
  logic                wrDone, rdDone;
  int unsigned         frameDepth;

  always_comb begin
    frameDepth = TOTAL_WORDS >> frameShift(stb.chanM1);
    cap        = CW'(frameDepth * (32'(stb.chanM1) + 32'd1));
  end

  assign wrDone      = stb.push && (wrSub == stb.chanM1);
  assign rdDone      = stb.pop  && (rdSub == stb.chanM1);
  assign fill.full   = (count >= cap);
  assign fill.empty  = (count == '0);
  assign fill.frames = frames;

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= stb.pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      wrSub  <= '0;
      rdSub  <= '0;
      frames <= '0;
    end else begin
      if (stb.push) begin
        wrPtr <= wrPtr + 1'b1;
        wrSub <= wrDone ? '0 : wrSub + 1'b1;
      end
      if (stb.pop) begin
        rdPtr <= rdPtr + 1'b1;
        rdSub <= rdDone ? '0 : rdSub + 1'b1;
      end
      count  <= count + CW'(stb.push) - CW'(stb.pop);
      frames <= frames + RES_W'(wrDone) - RES_W'(rdDone);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            serData <= '0;
    else if (stb.pop)     serData <= mem[rdPtr];
    else if (stb.popMiss) serData <= '0;
  end

  // Storage never holds more samples than the pool has words.
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(TOTAL_WORDS));

  // A clear leaves the FIFO empty on the next cycle.
  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (fill.empty && fill.frames == '0));

  // A pull from an empty FIFO drives zero toward the serializer.
  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.popMiss && !stb.pop) |=> serData == '0);

  // The fill count does not move when there is neither a push nor a pop.
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.push && !stb.pop && !stb.clear) |=> $stable(count));
endmodule

// File: rtl/achfifo_ctrl.sv
module achfifo_ctrl
  import achfifo_pkg::*;
#(
  parameter int TOTAL_WORDS = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWdata,
  input  logic        serPop,
  input  fill_t       fill,
  output strobe_t     stb,
  output logic [31:0] regRdata,
  output logic        halfReq
);
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam int BIT_CLEAR = 0;
  localparam int BIT_HALF  = 20;
  localparam int BIT_CHAN  = 8;
  localparam int BIT_OVR   = 4;
  localparam int BIT_UND   = 0;
  localparam int BIT_RES   = 8;

  logic [SAMPLE_W-1:0] keptData;
  logic                ctrlWr, statWr, dataWr;
  logic [CHAN_W-1:0]   chanM1;
  logic                halfEn;
  logic                ovrFlag, undFlag;
  logic [RES_W-1:0]    halfFrames;

  assign keptData = regWdata[SAMPLE_W-1:0];
  assign ctrlWr   = regWrEn && (regAddr == ADDR_CTRL);
  assign statWr   = regWrEn && (regAddr == ADDR_STAT);
  assign dataWr   = regWrEn && (regAddr == ADDR_DATA);

  always_comb begin
    stb          = '0;
    stb.clear    = ctrlWr && keptData[BIT_CLEAR];
    stb.push     = dataWr && !fill.full;
    stb.pushData = keptData;
    stb.pop      = serPop && !fill.empty;
    stb.popMiss  = serPop && fill.empty;
    stb.chanM1   = chanM1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanM1 <= '0;
      halfEn <= 1'b0;
    end else if (ctrlWr) begin
      chanM1 <= keptData[BIT_CHAN +: CHAN_W];
      halfEn <= keptData[BIT_HALF];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovrFlag <= 1'b0;
      undFlag <= 1'b0;
    end else begin
      ovrFlag <= (ovrFlag && !(statWr && !keptData[BIT_OVR])) || (dataWr && fill.full);
      undFlag <= (undFlag && !(statWr && !keptData[BIT_UND])) || stb.popMiss;
    end
  end

  assign halfFrames = RES_W'((TOTAL_WORDS >> frameShift(chanM1)) >> 1);
  assign halfReq    = halfEn && (fill.frames <= halfFrames);

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdata[BIT_HALF]            = halfEn;
        regRdata[BIT_CHAN +: CHAN_W]  = chanM1;
      end
      ADDR_STAT: begin
        regRdata[BIT_RES +: RES_W]    = fill.frames;
        regRdata[BIT_OVR]             = ovrFlag;
        regRdata[BIT_UND]             = undFlag;
      end
      default: regRdata = '0;
    endcase
  end

  // Overrun only appears after a sample write met a full FIFO.
  assert_ovr_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> $past(dataWr && fill.full));

  // Underrun stays set until a status write.
  assert_und_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (undFlag && !statWr) |=> undFlag);

  // A zero written to status clears overrun.
  assert_stat_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && keptData == '0) |=> !ovrFlag);
endmodule

// File: rtl/audio_chan_fifo.sv
module audio_chan_fifo
  import achfifo_pkg::*;
#(
  parameter int TOTAL_WORDS = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        serPop,
  output logic [23:0] serData,
  output logic        halfReq
);
  strobe_t stb;
  fill_t   fill;

  achfifo_ctrl #(.TOTAL_WORDS(TOTAL_WORDS)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .serPop   (serPop),
    .fill     (fill),
    .stb      (stb),
    .regRdata (regRdata),
    .halfReq  (halfReq)
  );

  achfifo_data #(.TOTAL_WORDS(TOTAL_WORDS)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .fill    (fill),
    .serData (serData)
  );
endmodule

// File: tb/sim_audio_chan_fifo.sv
module sim_audio_chan_fifo;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [1:0]  regAddr;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic        serPop;
  logic [23:0] serData;
  logic        halfReq;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_chan_fifo u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .serPop(serPop),
    .serData(serData), .halfReq(halfReq)
  );

  int checks = 0;
  int errors = 0;

  // Reference model state
  int q[$];
  int pushed, popped, chanN, expSer;
  bit halfEnM, ovrM, undM;

  function automatic int depthOf(input int n);
    if (n == 1) return 256;
    if (n == 2) return 128;
    if (n <= 4) return 64;
    return 32;
  endfunction

  function automatic int framesM();
    return pushed / chanN - popped / chanN;
  endfunction

  function automatic logic [31:0] expStatus();
    return (32'(framesM()) << 8) | (32'(ovrM) << 4) | 32'(undM);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelStep(input bit wr, input logic [1:0] a, input logic [31:0] d, input bit pop);
    int w = int'(d & 32'h00FF_FFFF);
    int cap = depthOf(chanN) * chanN;
    bit emptyPre = (q.size() == 0);
    bit fullPre = (q.size() >= cap);
    bit miss = pop && emptyPre;
    if (pop) begin
      if (emptyPre) expSer = 0;
      else begin expSer = q.pop_front(); popped++; end
    end
    if (wr && a == 2'd2) begin
      if (fullPre) ovrM = 1;
      else begin q.push_back(w); pushed++; end
    end
    if (miss) undM = 1;
    if (wr && a == 2'd1) begin
      if (((w >> 4) & 1) == 0) ovrM = 0;
      if ((w & 1) == 0 && !miss) undM = 0;
    end
    if (wr && a == 2'd0) begin
      chanN = ((w >> 8) & 7) + 1;
      halfEnM = ((w >> 20) & 1) != 0;
      if ((w & 1) != 0) begin q.delete(); pushed = 0; popped = 0; end
    end
  endtask

  task automatic compareAll();
    logic [31:0] es = expStatus();
    bit eh = halfEnM && (framesM() <= depthOf(chanN) / 2);
    check(regRdata == es, "R2 status word", regRdata, es);
    check(halfReq == eh, "R7 halfReq", 32'(halfReq), 32'(eh));
    check(serData == 24'(expSer), "R9 serData order", 32'(serData), 32'(expSer));
  endtask

  task automatic cycle(input bit wr, input logic [1:0] a, input logic [31:0] d, input bit pop);
    regWrEn = wr; regAddr = a; regWdata = d; serPop = pop;
    @(posedge clk);
    modelStep(wr, a, d, pop);
    #1;
    regWrEn = 0; regAddr = 2'd1; regWdata = '0; serPop = 0;
    @(negedge clk);
    compareAll();
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdata;
    regAddr = 2'd1;
  endtask

  function automatic logic [31:0] sampleWord(input int i);
    return 32'hAB00_0000 | (32'(i * 4099) & 32'h00FF_FFFF);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int firstSample;
    rstN = 0; regWrEn = 0; regAddr = 2'd1; regWdata = '0; serPop = 0;
    pushed = 0; popped = 0; chanN = 1; expSer = 0;
    halfEnM = 0; ovrM = 0; undM = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    check(regRdata == 32'h0, "R10 status after reset", regRdata, 32'h0);
    check(halfReq == 1'b0, "R10 halfReq after reset", 32'(halfReq), 32'h0);
    check(serData == 24'h0, "R10 serData after reset", 32'(serData), 32'h0);
    readReg(2'd0, v);
    check(v == 32'h0, "R10 control after reset", v, 32'h0);

    // Two channels, half request on, clear
    cycle(1, 2'd0, 32'h0010_0101, 0);
    readReg(2'd0, v);
    check(v == 32'h0010_0100, "R6 R8 control readback clear bit reads 0", v, 32'h0010_0100);
    for (int i = 0; i < 5; i++) cycle(1, 2'd2, sampleWord(i), 0);
    check(regRdata[16:8] == 9'd2, "R2 five samples two channels", 32'(regRdata[16:8]), 32'd2);
    for (int i = 5; i < 257; i++) cycle(1, 2'd2, sampleWord(i), 0);
    check(regRdata[16:8] == 9'd128, "R1 two channel depth", 32'(regRdata[16:8]), 32'd128);
    check(regRdata[4] == 1'b1, "R3 overrun on full write", 32'(regRdata[4]), 32'd1);
    readReg(2'd2, v);
    check(v == 32'h0, "R8 data address reads 0", v, 32'h0);

    firstSample = int'(sampleWord(0) & 32'h00FF_FFFF);
    cycle(0, 2'd1, '0, 1);
    check(serData == 24'(firstSample), "R8 sample keeps low 24 bits", 32'(serData), 32'(firstSample));
    for (int i = 1; i < 256; i++) cycle(0, 2'd1, '0, 1);
    cycle(0, 2'd1, '0, 1);
    check(serData == 24'h0, "R4 empty pull gives zero", 32'(serData), 32'h0);
    check(regRdata[0] == 1'b1, "R4 underrun flag", 32'(regRdata[0]), 32'd1);

    cycle(1, 2'd1, 32'h0000_0011, 0);
    check(regRdata[4] && regRdata[0], "R5 ones leave flags", regRdata, 32'h11);
    cycle(1, 2'd1, 32'h0000_0000, 0);
    check(regRdata[4:0] == 5'h0, "R5 zero clears flags", regRdata, 32'h0);

    // Three channels
    cycle(1, 2'd0, 32'h0000_0201, 0);
    for (int i = 0; i < 200; i++) cycle(1, 2'd2, sampleWord(i + 300), 0);
    check(regRdata[16:8] == 9'd64, "R1 three channel depth", 32'(regRdata[16:8]), 32'd64);
    check(regRdata[4] == 1'b1, "R3 overrun three channels", 32'(regRdata[4]), 32'd1);
    cycle(1, 2'd0, 32'h0000_0201, 0);
    check(regRdata == 32'h10, "R6 clear empties keeps flag", regRdata, 32'h10);

    // One channel, half threshold
    cycle(1, 2'd1, 32'h0, 0);
    cycle(1, 2'd0, 32'h0010_0001, 0);
    for (int i = 0; i < 128; i++) cycle(1, 2'd2, sampleWord(i + 600), 0);
    check(halfReq == 1'b1, "R7 at half depth", 32'(halfReq), 32'd1);
    cycle(1, 2'd2, sampleWord(999), 0);
    check(halfReq == 1'b0, "R7 above half depth", 32'(halfReq), 32'd0);
    cycle(0, 2'd1, '0, 1);
    check(halfReq == 1'b1, "R7 back to half", 32'(halfReq), 32'd1);
    for (int i = 0; i < 6; i++) cycle(1, 2'd2, sampleWord(i + 1200), 1);

    // Eight channels, upper write bits ignored
    cycle(1, 2'd0, 32'hFF00_0701, 0);
    readReg(2'd0, v);
    check(v == 32'h0000_0700, "R8 control upper bits ignored", v, 32'h700);
    for (int i = 0; i < 260; i++) cycle(1, 2'd2, sampleWord(i + 2000), 0);
    check(regRdata[16:8] == 9'd32, "R1 eight channel depth", 32'(regRdata[16:8]), 32'd32);
    for (int i = 0; i < 9; i++) cycle(0, 2'd1, '0, 1);
    check(regRdata[16:8] == 9'd31, "R2 partial frame pulled", 32'(regRdata[16:8]), 32'd31);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule